// File: doc/BRIEF.md
# Up-Counting Compare Timer with Autorestart

This block is one timer channel of a memory-mapped system controller. Software writes a compare value, optionally preloads the counter, and sets the run bit in the control register. From the next clock on, the counter steps up by one on every clock. When it is equal to the compare value, the block raises an interrupt for a single clock. It then either reloads the counter to zero and keeps running (periodic mode) or clears its own run bit and stops with the counter parked on the compare value (one-shot mode).

The parent controller places two instances side by side. Each instance gets its own register select and write strobe from a bus decoder outside this block. The counter and the control bits can be read back at any time. The counter runs at the system clock rate, which is 80 MHz by default in the parent. The interrupt output is a registered single-cycle pulse meant for an external interrupt controller.

Top module: `cmp_up_timer`

## Requirements
- R1: After reset the control, compare and counter registers read zero, the timer is stopped and the interrupt output is low.
- R2: Register select code 0 is control (bit 0 = run, bit 1 = autorestart, other bits read zero), code 1 is compare and code 2 is counter. Code 3 reads zero, and a write to it changes no register.
- R3: While run is set and the counter differs from compare, the counter steps up by one per clock. It starts from whatever value it held when run was set.
- R4: While run is clear, the counter holds its value.
- R5: A clock edge where run is set and the counter equals compare is a hit. The interrupt output is high for exactly the one cycle after that edge.
- R6: On a hit with autorestart clear, hardware clears the run bit and the counter stays at the compare value.
- R7: On a hit with autorestart set, the counter becomes zero and run stays set, so the interrupt repeats every compare+1 clocks.
- R8: A counter preloaded above compare counts through the all-ones value, wraps to zero and hits when it reaches compare.
- R9: A software counter write on a hit edge takes priority over the reload to zero, but the interrupt still fires.
- R10: A software control write on a one-shot hit edge takes priority over the hardware clear of the run bit.
- R11: Compare may be rewritten while the timer runs; the new value is used for hit detection from the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the counter steps on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| wrSel | input | 2 | Register select for writes (0 control, 1 compare, 2 counter) |
| wrData | input | WIDTH | Write data |
| rdSel | input | 2 | Register select for the combinational read port |
| rdData | output | WIDTH | Read data for the selected register |
| irqPulse | output | 1 | Interrupt, high for one clock after each hit |

## Verification
The timer is run in one-shot mode from a preload below compare, in periodic mode from zero, and from a preload near all-ones that must wrap before it hits. These runs separate the wrong hit cycle, a wrong reload value and a missing wrap. Holding with run clear separates a free-running counter from a gated one. Resuming after a one-shot stop shows whether the counter restarts from its held value or from zero. Writes that land exactly on a hit edge, to the counter in periodic mode and to control in one-shot mode, show the chosen priorities. A compare rewrite mid-run shows whether the new value is picked up at once.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // register select codes shared by the write and read ports
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CMP  = 2'd1,
    SEL_CNT  = 2'd2,
    SEL_NONE = 2'd3
  } regSel_t;

  // control register bit positions
  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_AR_BIT  = 1;

  // strobes from control to datapath, at most one counter action per cycle
  typedef struct packed {
    logic loadCnt;  // software counter write
    logic clrCnt;   // periodic reload to zero
    logic incCnt;   // normal step
    logic loadCmp;  // software compare write
  } tmrStrobes_t;

endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [1:0]  wrSel,
  input  logic [1:0]  wrCtrlBits,
  input  logic        atCompare,
  output logic        runQ,
  output logic        autoRestartQ,
  output logic        irqQ,
  output tmrStrobes_t strobes
);

  logic ctrlWrite;
  logic cntWrite;
  logic hit;

  assign ctrlWrite = wrEn && (wrSel == SEL_CTRL);
  assign cntWrite  = wrEn && (wrSel == SEL_CNT);
  assign hit       = runQ && atCompare;

  // counter actions: software load beats reload, reload beats step
  always_comb begin
    strobes         = '0;
    strobes.loadCnt = cntWrite;
    strobes.loadCmp = wrEn && (wrSel == SEL_CMP);
    strobes.clrCnt  = hit && autoRestartQ && !cntWrite;
    strobes.incCnt  = runQ && !hit && !cntWrite;
  end

  // control bits: software write beats the one-shot clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ         <= 1'b0;
      autoRestartQ <= 1'b0;
    end else if (ctrlWrite) begin
      runQ         <= wrCtrlBits[CTRL_RUN_BIT];
      autoRestartQ <= wrCtrlBits[CTRL_AR_BIT];
    end else if (hit && !autoRestartQ) begin
      runQ <= 1'b0;
    end
  end

  // interrupt is registered: one clock wide per hit
  always_ff @(posedge clk) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= hit;
  end

endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobes_t      strobes,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] countQ,
  output logic [WIDTH-1:0] compareQ,
  output logic             atCompare
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_ff @(posedge clk) begin
    if (!rstN)                compareQ <= '0;
    else if (strobes.loadCmp) compareQ <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               countQ <= '0;
    else if (strobes.loadCnt) countQ <= wrData;
    else if (strobes.clrCnt)  countQ <= '0;
    else if (strobes.incCnt)  countQ <= countQ + ONE;
  end

  assign atCompare = (countQ == compareQ);

endmodule

// File: rtl/cmp_up_timer.sv
module cmp_up_timer
  import tmr_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrSel,
  input  logic [WIDTH-1:0] wrData,
  input  logic [1:0]       rdSel,
  output logic [WIDTH-1:0] rdData,
  output logic             irqPulse
);

  localparam int CTRL_PAD = WIDTH - 2;

  tmrStrobes_t      strobes;
  logic             ctrlRun;
  logic             ctrlAutoRestart;
  logic             atCompare;
  logic [WIDTH-1:0] countVal;
  logic [WIDTH-1:0] compareVal;

  tmr_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .wrEn         (wrEn),
    .wrSel        (wrSel),
    .wrCtrlBits   (wrData[1:0]),
    .atCompare    (atCompare),
    .runQ         (ctrlRun),
    .autoRestartQ (ctrlAutoRestart),
    .irqQ         (irqPulse),
    .strobes      (strobes)
  );

  tmr_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .wrData    (wrData),
    .countQ    (countVal),
    .compareQ  (compareVal),
    .atCompare (atCompare)
  );

  always_comb begin
    case (rdSel)
      SEL_CTRL: rdData = {{CTRL_PAD{1'b0}}, ctrlAutoRestart, ctrlRun};
      SEL_CMP:  rdData = compareVal;
      SEL_CNT:  rdData = countVal;
      default:  rdData = '0;
    endcase
  end

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic             irqPulse,
  input logic             run,
  input logic             autoRestart,
  input logic [WIDTH-1:0] count,
  input logic [WIDTH-1:0] compare
);

  // R5: interrupt only after a hit edge
  p_irq_after_hit_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqPulse) |-> ($past(run) && ($past(count) == $past(compare))));

  // R5: single-cycle width when no write disturbed the hit
  p_irq_width_r5: assert property (@(posedge clk) disable iff (!rstN)
    (irqPulse && !wrEn && $past(!wrEn) && (compare != '0)) |=> !irqPulse);

  // R3: step by one between hits
  p_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (run && (count != compare) && !wrEn) |=> (count == $past(count) + WIDTH'(1)));

  // R4: hold while stopped
  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!run && !wrEn) |=> $stable(count));

  // R6: one-shot hit stops the timer at compare
  p_oneshot_stop_r6: assert property (@(posedge clk) disable iff (!rstN)
    (run && !autoRestart && (count == compare) && !wrEn) |=> (!run && $stable(count)));

  // R7: periodic hit reloads to zero and keeps running
  p_reload_r7: assert property (@(posedge clk) disable iff (!rstN)
    (run && autoRestart && (count == compare) && !wrEn) |=> (run && (count == '0)));

endmodule

bind cmp_up_timer tmr_checker #(.WIDTH(WIDTH)) u_tmr_checker (
  .clk         (clk),
  .rstN        (rstN),
  .wrEn        (wrEn),
  .irqPulse    (irqPulse),
  .run         (ctrlRun),
  .autoRestart (ctrlAutoRestart),
  .count       (countVal),
  .compare     (compareVal)
);

// File: tb/test_cmp_up_timer.sv
module test_cmp_up_timer;

  localparam int WIDTH = 32;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             wrEn = 1'b0;
  logic [1:0]       wrSel = 2'd0;
  logic [WIDTH-1:0] wrData = '0;
  logic [1:0]       rdSel = 2'd0;
  logic [WIDTH-1:0] rdData;
  logic             irqPulse;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  cmp_up_timer #(.WIDTH(WIDTH)) i_cmp_up_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rdSel(rdSel), .rdData(rdData), .irqPulse(irqPulse)
  );

  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [WIDTH-1:0] act,
                       input logic [WIDTH-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, captured by the next rising edge
  task automatic regWrite(input logic [1:0] sel, input logic [WIDTH-1:0] data);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0; wrSel = 2'd0; wrData = '0;
  endtask

  task automatic regRead(input logic [1:0] sel, output logic [WIDTH-1:0] data);
    rdSel = sel;
    #1;
    data = rdData;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectReg(input string tag, input logic [1:0] sel,
                           input logic [WIDTH-1:0] exp);
    logic [WIDTH-1:0] v;
    regRead(sel, v);
    check(tag, v, exp);
  endtask

  task automatic stopAndClear();
    regWrite(2'd0, '0);
    regWrite(2'd2, '0);
    step(1);
  endtask

  task automatic testReset();
    expectReg("R1 control", 2'd0, '0);
    expectReg("R1 compare", 2'd1, '0);
    expectReg("R1 counter", 2'd2, '0);
    check("R1 irq", WIDTH'(irqPulse), '0);
  endtask

  task automatic testRegMap();
    regWrite(2'd1, 32'h0000_1234);
    regWrite(2'd2, 32'h0000_0005);
    regWrite(2'd0, 32'hFFFF_FFFE);   // autorestart only, run clear
    expectReg("R2 compare readback", 2'd1, 32'h0000_1234);
    expectReg("R2 counter readback", 2'd2, 32'h0000_0005);
    expectReg("R2 control bits", 2'd0, 32'h0000_0002);
    regWrite(2'd3, 32'hDEAD_BEEF);
    expectReg("R2 code3 reads zero", 2'd3, '0);
    expectReg("R2 code3 write ignored cmp", 2'd1, 32'h0000_1234);
    expectReg("R2 code3 write ignored cnt", 2'd2, 32'h0000_0005);
  endtask

  task automatic testHold();
    regWrite(2'd0, '0);
    step(4);
    expectReg("R4 counter held", 2'd2, 32'h0000_0005);
    check("R4 no irq", WIDTH'(irqPulse), '0);
  endtask

  task automatic testOneShot();
    regWrite(2'd1, 32'd14);
    regWrite(2'd2, 32'd10);
    regWrite(2'd0, 32'd1);
    step(2);
    expectReg("R3 counting", 2'd2, 32'd12);
    step(2);
    expectReg("R3 at compare", 2'd2, 32'd14);
    check("R5 no early irq", WIDTH'(irqPulse), '0);
    step(1);
    check("R5 irq on hit", WIDTH'(irqPulse), 1);
    expectReg("R6 run cleared", 2'd0, '0);
    expectReg("R6 counter parked", 2'd2, 32'd14);
    step(1);
    check("R5 irq one cycle", WIDTH'(irqPulse), '0);
    expectReg("R6 still parked", 2'd2, 32'd14);
    // resume from held value
    regWrite(2'd1, 32'd30);
    regWrite(2'd0, 32'd1);
    step(3);
    expectReg("R3 resume from held", 2'd2, 32'd17);
    stopAndClear();
  endtask

  task automatic testPeriodic();
    regWrite(2'd1, 32'd3);
    regWrite(2'd0, 32'd3);
    step(3);
    expectReg("R7 reached compare", 2'd2, 32'd3);
    step(1);
    check("R7 irq first", WIDTH'(irqPulse), 1);
    expectReg("R7 reload zero", 2'd2, '0);
    expectReg("R7 run kept", 2'd0, 32'd3);
    step(1);
    expectReg("R7 counting again", 2'd2, 32'd1);
    check("R7 irq dropped", WIDTH'(irqPulse), '0);
    step(3);
    check("R7 period compare+1", WIDTH'(irqPulse), 1);
    stopAndClear();
  endtask

  task automatic testWrap();
    regWrite(2'd1, 32'd1);
    regWrite(2'd2, 32'hFFFF_FFFE);
    regWrite(2'd0, 32'd1);
    step(1);
    expectReg("R8 all ones", 2'd2, 32'hFFFF_FFFF);
    step(1);
    expectReg("R8 wrapped", 2'd2, '0);
    check("R8 no irq at wrap", WIDTH'(irqPulse), '0);
    step(2);
    check("R8 irq after wrap", WIDTH'(irqPulse), 1);
    stopAndClear();
  endtask

  task automatic testCntWriteOnHit();
    regWrite(2'd1, 32'd2);
    regWrite(2'd0, 32'd3);
    step(2);
    regWrite(2'd2, 32'd7);   // lands on the hit edge
    expectReg("R9 write beats reload", 2'd2, 32'd7);
    check("R9 irq still fires", WIDTH'(irqPulse), 1);
    stopAndClear();
  endtask

  task automatic testCtrlWriteOnHit();
    regWrite(2'd1, 32'd2);
    regWrite(2'd0, 32'd1);
    step(2);
    regWrite(2'd0, 32'd1);   // lands on the one-shot hit edge
    expectReg("R10 run kept by write", 2'd0, 32'd1);
    check("R10 irq on hit", WIDTH'(irqPulse), 1);
    step(1);
    expectReg("R10 second hit clears", 2'd0, '0);
    stopAndClear();
  endtask

  task automatic testCompareRewrite();
    regWrite(2'd1, 32'd100);
    regWrite(2'd0, 32'd1);
    step(3);
    regWrite(2'd1, 32'd5);
    expectReg("R11 counter at rewrite", 2'd2, 32'd4);
    step(1);
    check("R11 no irq yet", WIDTH'(irqPulse), '0);
    step(1);
    check("R11 hit on new compare", WIDTH'(irqPulse), 1);
    stopAndClear();
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);
    testReset();
    testRegMap();
    testHold();
    testOneShot();
    testPeriodic();
    testWrap();
    testCntWriteOnHit();
    testCtrlWriteOnHit();
    testCompareRewrite();
    finished = 1'b1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      report();
    end
  end

endmodule